// File: doc/BRIEF.md
# NOR Flash Command Interface Model

This block models a 16-bit parallel NOR flash behind a simple synchronous bus: word address, write data, a write strobe, a read strobe and registered read data. Its storage is an array of equal sectors that starts out erased. Writes are not stored directly. A command decoder follows multi-write unlock sequences and turns them into word program, sector erase, chip erase, an identification read mode, a geometry query read mode and an unlock-bypass mode. In unlock-bypass mode, programming needs two writes instead of four.

An erase keeps the part busy for a parameterised number of cycles. During that time every read returns a polling status word instead of array data, and all writes are ignored. Programming completes at once and can only clear bits. Host-side code uses the unlock and polling conventions exactly as it would on a real part.

Top module: `nor_flash_model`

## Requirements
- R1: After reset `rdata_o` is 0x0000, every array word reads 0xFFFF, and the block is in array-read mode. `rdata_o` loads on the clock edge where `re_i` is high and holds its value otherwise.
- R2: Command addresses are compared on their low 11 bits only. For example, 0x5555 and 0x2AAA act as 0x555 and 0x2AA. An unlock is 0x00AA written to 0x555 followed by 0x0055 written to 0x2AA. Only the low data byte is decoded.
- R3: An unlock followed by 0x90 at 0x555 enters identification mode. In that mode word 0 reads 0x00BF, word 1 reads 0x236D, and other words read 0x0000. Any write, such as 0xF0, returns the block to array reads.
- R4: 0x98 written to 0x55 in array mode enters query mode. Words 0x10, 0x11 and 0x12 then read 0x0051, 0x0052 and 0x0059. Any write returns the block to array reads.
- R5: In query mode, word 0x2C reads 0x0001. Words 0x2D and 0x2E read the low and high bytes of (sectors − 1). Words 0x2F and 0x30 read the low and high bytes of the sector size in 256-byte units. With the defaults these are 0x0F, 0x00, 0x02 and 0x00.
- R6: An unlock, then 0xA0 at 0x555, then a data write to any word replaces that word with old AND new. Programming 0x0055 and then 0x00A5 into an erased word leaves 0x0005.
- R7: An unlock, 0x80 at 0x555, a second unlock, then 0x30 at any word of a sector erases only that sector.
- R8: The same sequence, ending instead with 0x10 at 0x555, erases every sector.
- R9: An erase is busy for ERASE_CYCLES cycles after its final write. Each read during that time returns 0x0000 with bit 6 set to a toggle bit. The toggle bit is 0 after reset and inverts after every busy read. Writes during the busy time have no effect. After completion, repeated reads are identical and erased words read 0xFFFF.
- R10: An unlock followed by 0x20 at 0x555 enters bypass mode. In bypass mode, 0xA0 at any address followed by a data write programs that word, and array reads work normally. A write of 0x00 leaves the mode, after which a two-write program changes nothing.
- R11: A write that does not match the expected next step of a sequence returns the decoder to array mode without performing any operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 16 | Write data / command |
| we_i | input | 1 | Write strobe, one cycle per write |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |

## Verification
Every read result appears on `rdata_o` one edge after the cycle in which `re_i` is high. The read task queues its expected word when it raises `re_i`. A monitor then pops and compares that word on the falling edge that follows, so each comparison lands exactly in the cycle the data is due. Command writes take effect at the edge where they are strobed, so a read issued in the next cycle already sees the new mode. Busy status reads are issued within the first few cycles after an erase's final write, well inside the ERASE_CYCLES window. Completion is checked only after ERASE_CYCLES plus two idle cycles.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;
  typedef enum logic [3:0] {
    ST_ARRAY, ST_UL1, ST_UL2, ST_PGM, ST_ER0, ST_ER1, ST_ER2,
    ST_ID, ST_QRY, ST_BYP, ST_BYP_PGM
  } cmd_state_e;

  typedef enum logic [1:0] {RD_ARRAY, RD_ID, RD_QRY} rd_mode_e;

  localparam logic [7:0] C_UL_A   = 8'hAA;
  localparam logic [7:0] C_UL_B   = 8'h55;
  localparam logic [7:0] C_ID     = 8'h90;
  localparam logic [7:0] C_QRY    = 8'h98;
  localparam logic [7:0] C_PGM    = 8'hA0;
  localparam logic [7:0] C_ERSETUP = 8'h80;
  localparam logic [7:0] C_ER_SEC = 8'h30;
  localparam logic [7:0] C_ER_CHIP = 8'h10;
  localparam logic [7:0] C_BYP    = 8'h20;
  localparam logic [7:0] C_BYP_EXIT = 8'h00;
endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_flash_pkg::*;
#(
  parameter int CMD_BITS = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [CMD_BITS-1:0] caddr_i,
  input  logic [7:0]          cdata_i,
  input  logic                busy_i,
  output logic                prog_o,
  output logic                erase_o,
  output logic                chip_o,
  output rd_mode_e            rd_mode_o
);
  cmd_state_e state_q, state_d;
  logic at_555, at_2aa, at_055, wr;

  assign at_555 = caddr_i == CMD_BITS'(12'h555);
  assign at_2aa = caddr_i == CMD_BITS'(12'h2AA);
  assign at_055 = caddr_i == CMD_BITS'(12'h055);
  assign wr     = we_i && !busy_i;

  always_comb begin
    state_d = state_q;
    prog_o  = 1'b0;
    erase_o = 1'b0;
    chip_o  = 1'b0;
    if (wr) begin
      state_d = ST_ARRAY;  // default: abort to array reads
      unique case (state_q)
        ST_ARRAY: begin
          if (at_555 && cdata_i == C_UL_A) state_d = ST_UL1;
          else if (at_055 && cdata_i == C_QRY) state_d = ST_QRY;
        end
        ST_UL1: if (at_2aa && cdata_i == C_UL_B) state_d = ST_UL2;
        ST_UL2: if (at_555) begin
          case (cdata_i)
            C_ID:      state_d = ST_ID;
            C_PGM:     state_d = ST_PGM;
            C_ERSETUP: state_d = ST_ER0;
            C_BYP:     state_d = ST_BYP;
            default:   state_d = ST_ARRAY;
          endcase
        end
        ST_PGM: prog_o = 1'b1;
        ST_ER0: if (at_555 && cdata_i == C_UL_A) state_d = ST_ER1;
        ST_ER1: if (at_2aa && cdata_i == C_UL_B) state_d = ST_ER2;
        ST_ER2: begin
          if (cdata_i == C_ER_SEC) erase_o = 1'b1;
          else if (at_555 && cdata_i == C_ER_CHIP) begin
            erase_o = 1'b1;
            chip_o  = 1'b1;
          end
        end
        ST_BYP: begin
          if (cdata_i == C_PGM) state_d = ST_BYP_PGM;
        end
        ST_BYP_PGM: begin
          prog_o  = 1'b1;
          state_d = ST_BYP;
        end
        default: state_d = ST_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_ARRAY;
    else         state_q <= state_d;

  always_comb
    case (state_q)
      ST_ID:   rd_mode_o = RD_ID;
      ST_QRY:  rd_mode_o = RD_QRY;
      default: rd_mode_o = RD_ARRAY;
    endcase

  assert_busy_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !(prog_o || erase_o));
  assert_abort_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && state_q == ST_UL1 && !at_2aa) |=> state_q == ST_ARRAY);
endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int SECTORS      = 16,
  parameter int SECTOR_WORDS = 256,
  parameter int ERASE_CYCLES = 1000,
  localparam int WORDS  = SECTORS * SECTOR_WORDS,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int SEC_SH = $clog2(SECTOR_WORDS),
  localparam int CNT_W  = $clog2(ERASE_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_i,
  input  logic             erase_i,
  input  logic             chip_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rd_word_o,
  output logic             busy_o
);
  logic [15:0]      mem [WORDS];
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] sec_q;
  logic             chip_q, fire;

  assign busy_o    = cnt_q != '0;
  assign fire      = cnt_q == CNT_W'(1);
  assign rd_word_o = mem[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q  <= '0;
      sec_q  <= '0;
      chip_q <= 1'b0;
    end else if (erase_i) begin
      cnt_q  <= CNT_W'(ERASE_CYCLES);
      sec_q  <= idx_i >> SEC_SH;
      chip_q <= chip_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (fire && (chip_q || (IDX_W'(i) >> SEC_SH) == sec_q)) mem[i] <= '1;
        else if (prog_i && idx_i == IDX_W'(i)) mem[i] <= mem[i] & wdata_i;
      end
    end

  assert_erase_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> busy_o);
  assert_prog_clears_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> ((mem[$past(idx_i)] & ~$past(rd_word_o)) == 16'h0000));
endmodule

// File: rtl/nor_info_rom.sv
module nor_info_rom
  import nor_flash_pkg::*;
#(
  parameter int SECTORS      = 16,
  parameter int SECTOR_WORDS = 256
) (
  input  rd_mode_e    mode_i,
  input  logic [7:0]  a_i,
  output logic [15:0] info_o
);
  localparam logic [15:0] SEC_M1 = 16'(SECTORS - 1);
  localparam logic [15:0] SZ_U   = 16'(SECTOR_WORDS * 2 / 256);

  always_comb begin
    info_o = 16'h0000;
    if (mode_i == RD_ID) begin
      if (a_i == 8'h00)      info_o = 16'h00BF;
      else if (a_i == 8'h01) info_o = 16'h236D;
    end else begin
      case (a_i)
        8'h10: info_o = 16'h0051;
        8'h11: info_o = 16'h0052;
        8'h12: info_o = 16'h0059;
        8'h2C: info_o = 16'h0001;
        8'h2D: info_o = {8'h00, SEC_M1[7:0]};
        8'h2E: info_o = {8'h00, SEC_M1[15:8]};
        8'h2F: info_o = {8'h00, SZ_U[7:0]};
        8'h30: info_o = {8'h00, SZ_U[15:8]};
        default: info_o = 16'h0000;
      endcase
    end
  end
endmodule

// File: rtl/nor_flash_model.sv
module nor_flash_model
  import nor_flash_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int SECTORS      = 16,
  parameter int SECTOR_WORDS = 256,
  parameter int ERASE_CYCLES = 1000,
  parameter int CMD_BITS     = 11,
  localparam int IDX_W       = $clog2(SECTORS * SECTOR_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [15:0]       rdata_o
);
  logic        busy, prog, erase, chip, tog_q;
  logic [15:0] arr_word, info_word;
  rd_mode_e    mode;
  logic        unused_bits;

  assign unused_bits = ^{addr_i, wdata_i};

  nor_cmd_fsm #(.CMD_BITS(CMD_BITS)) u_fsm (
    .clk_i, .rst_ni, .we_i,
    .caddr_i(addr_i[CMD_BITS-1:0]), .cdata_i(wdata_i[7:0]),
    .busy_i(busy), .prog_o(prog), .erase_o(erase), .chip_o(chip),
    .rd_mode_o(mode)
  );

  nor_array #(.SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS),
              .ERASE_CYCLES(ERASE_CYCLES)) u_array (
    .clk_i, .rst_ni, .prog_i(prog), .erase_i(erase), .chip_i(chip),
    .idx_i(addr_i[IDX_W-1:0]), .wdata_i, .rd_word_o(arr_word), .busy_o(busy)
  );

  nor_info_rom #(.SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS)) u_info (
    .mode_i(mode), .a_i(addr_i[7:0]), .info_o(info_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rdata_o <= '0;
      tog_q   <= 1'b0;
    end else if (re_i) begin
      if (busy) begin
        rdata_o <= {9'b0, tog_q, 6'b0};
        tog_q   <= ~tog_q;
      end else if (mode != RD_ARRAY) begin
        rdata_o <= info_word;
      end else begin
        rdata_o <= arr_word;
      end
    end

  assert_busy_dq7_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && re_i) |=> rdata_o[7] == 1'b0);
  assert_rdata_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
  assert_qry_sig_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && mode == RD_QRY && re_i && addr_i[7:0] == 8'h10) |=> rdata_o == 16'h0051);
  assert_id_mfr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && mode == RD_ID && re_i && addr_i[7:0] == 8'h00) |=> rdata_o == 16'h00BF);
endmodule

// File: tb/tb_nor_flash_model.sv
module tb_nor_flash_model;
  localparam int EC = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  logic rd_pend = 1'b0;
  logic tog = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  nor_flash_model #(.ERASE_CYCLES(EC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata)
  );

  always @(posedge clk) rd_pend <= re;

  always @(negedge clk) begin
    if (rd_pend) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [15:0] e, input string t);
    addr = a; re = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    re = 1'b0;
  endtask

  // busy read: status word carries the toggle bit, which then inverts
  task automatic rd_busy(input string t);
    rd(16'h0000, {9'b0, tog, 6'b0}, t);
    tog = ~tog;
  endtask

  task automatic unlock();
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(2);
    checks++;
    if (rdata !== 16'h0000) begin
      errors++;
      $display("FAIL R1 reset rdata: got %h expected 0000", rdata);
    end
    rst_n = 1'b1;
    idle(1);
    rd(16'h0000, 16'hFFFF, "R1 erased word 0");
    rd(16'h0FFF, 16'hFFFF, "R1 erased last word");

    // R6 program, AND-only
    unlock(); wr(16'h0555, 16'h00A0); wr(16'h0100, 16'h0055);
    rd(16'h0100, 16'h0055, "R6 first program");
    unlock(); wr(16'h0555, 16'h00A0); wr(16'h0100, 16'h00A5);
    rd(16'h0100, 16'h0005, "R6 bits only clear");
    unlock(); wr(16'h0555, 16'h00A0); wr(16'h0005, 16'h1234);
    unlock(); wr(16'h0555, 16'h00A0); wr(16'h0305, 16'h0F00);
    rd(16'h0005, 16'h1234, "R6 sector0 word");
    rd(16'h0305, 16'h0F00, "R6 sector3 word");

    // R2 aliased addresses, R3 identification
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
    rd(16'h0000, 16'h00BF, "R2 R3 manufacturer");
    rd(16'h0001, 16'h236D, "R3 device");
    rd(16'h0002, 16'h0000, "R3 other word");
    wr(16'h0000, 16'h00F0);
    rd(16'h0005, 16'h1234, "R3 back to array");

    // R4/R5 query
    wr(16'h0055, 16'h0098);
    rd(16'h0010, 16'h0051, "R4 Q");
    rd(16'h0011, 16'h0052, "R4 R");
    rd(16'h0012, 16'h0059, "R4 Y");
    rd(16'h002C, 16'h0001, "R5 regions");
    rd(16'h002D, 16'h000F, "R5 count lo");
    rd(16'h002E, 16'h0000, "R5 count hi");
    rd(16'h002F, 16'h0002, "R5 size lo");
    rd(16'h0030, 16'h0000, "R5 size hi");
    wr(16'h0000, 16'h00F0);
    rd(16'h0100, 16'h0005, "R4 back to array");

    // R11 abort in mid-sequence
    unlock(); wr(16'h0555, 16'h0077); wr(16'h0555, 16'h00A0); wr(16'h0005, 16'h0000);
    rd(16'h0005, 16'h1234, "R11 aborted program");
    wr(16'h0555, 16'h00AA); wr(16'h0123, 16'h0055); wr(16'h0555, 16'h00A0); wr(16'h0305, 16'h0000);
    rd(16'h0305, 16'h0F00, "R11 bad second address");

    // R7 sector erase of sector 1 via an inner address, R9 status
    unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'h01AB, 16'h0030);
    rd_busy("R9 status read 1");
    rd_busy("R9 status read 2");
    unlock(); wr(16'h0555, 16'h00A0); wr(16'h0005, 16'h0000);
    rd_busy("R9 status read 3");
    idle(EC + 2);
    rd(16'h0100, 16'hFFFF, "R7 erased sector word");
    rd(16'h0100, 16'hFFFF, "R9 stable after erase");
    rd(16'h0005, 16'h1234, "R7 R9 other sector kept, busy write ignored");
    rd(16'h0305, 16'h0F00, "R7 sector3 kept");

    // R8 chip erase
    unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'h0555, 16'h0010);
    rd_busy("R8 R9 chip status 1");
    rd_busy("R8 R9 chip status 2");
    idle(EC + 2);
    rd(16'h0005, 16'hFFFF, "R8 sector0 erased");
    rd(16'h0305, 16'hFFFF, "R8 sector3 erased");
    rd(16'h0FFF, 16'hFFFF, "R8 last sector erased");

    // R10 bypass
    unlock(); wr(16'h0555, 16'h0020);
    wr(16'h0555, 16'h00A0); wr(16'h0000, 16'h0123);
    wr(16'h0777, 16'h00A0); wr(16'h0001, 16'h4567);
    rd(16'h0000, 16'h0123, "R10 bypass program");
    rd(16'h0001, 16'h4567, "R10 bypass any cmd address");
    wr(16'h0003, 16'h0000);
    wr(16'h0555, 16'h00A0); wr(16'h0002, 16'h0089);
    rd(16'h0002, 16'hFFFF, "R10 short program after exit");
    rd(16'h0000, 16'h0123, "R10 data kept after exit");

    idle(3);
    finish_run();
  end
endmodule